// File: doc/BRIEF.md
# Banked GPIO Port Register Core

This block holds all per-pin state of a 40-pin general purpose I/O expander arranged as five banks of eight pins. For every pin it stores a staged output value, a live output value, a direction bit, an input inversion bit and an interrupt mask bit. From that state it drives each pad's output level and drive enable. It also returns pad levels to the register reader, with any inversion applied.

A separate bus slave feeds it a write strobe with address and data. It also supplies a read address and single-cycle pulses that mark the bus STOP condition and each data-byte acknowledge. Output data written by the bus lands in a staged copy first. A mode bit picks which of the two bus events copies the staged values into the live register that reaches the pads.

A bank-override register can force the output pins of chosen banks to one common level. A per-bank choice selects push-pull or pull-down-only drive. A global output-enable pin, whose active level is programmable, can release every pad at once.

Address layout: `addr[5:3]` selects a group and `addr[2:0]` selects a bank. Group 0 is pad input (read-only), group 1 is output, group 2 is inversion, group 3 is direction and group 4 is mask. Group 5 holds the control registers: index 0 is open-drain bank enables in bits 4:0, index 1 is the override register (fill level in bit 7, bank enables in bits 4:0), and index 2 is mode (bit 0 = commit on acknowledge, bit 1 = output-enable pin active high). Pin n is bit n%8 of bank n/8.

Top module: `gpio_bank_core`

## Requirements
- R1: After reset every direction bit is 1 (input), output and inversion registers are 0, mask registers are 0xFF, the override register reads 0x80, open-drain and mode registers read 0, and no pad is driven.
- R2: Reading group 0 returns the live pad level of each pin XOR its inversion bit, whether the pin is an input or an output.
- R3: A write to the output group changes what reads back from that address at once, but the pads keep their previous level until the selected commit event.
- R4: With mode bit 0 clear, a STOP pulse commits staged output data to the pads, and acknowledge pulses have no effect on them.
- R5: With mode bit 0 set, an acknowledge pulse commits staged output data to the pads, and STOP pulses have no effect on them.
- R6: An output write that falls in the same cycle as the selected commit pulse is included in that commit.
- R7: For each bank whose override enable bit is set, the output pins drive the override fill level (bit 7) in place of the live output value. Clearing the enable restores the live value.
- R8: Pads may be driven only when the output-enable pin equals mode bit 1 (low-active by default). Otherwise every drive enable is 0.
- R9: In a bank with its open-drain bit set, a pin's driven level is 0 and it is driven only while its output value is 0. It never drives high.
- R10: Only pins whose direction bit is 0 are ever driven.
- R11: Writes to the pad input group or to a bank index of 5 or above change no state. Mask registers write and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| wr_addr | input | 6 | Write address (group in bits 5:3, bank in 2:0) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| stop_evt | input | 1 | One-cycle pulse at a bus STOP condition |
| ack_evt | input | 1 | One-cycle pulse at each data-byte acknowledge |
| oe_pin | input | 1 | Global output-enable pin |
| pad_in | input | 40 | Pad input levels |
| pad_out | output | 40 | Pad output levels |
| pad_oe | output | 40 | Pad drive enables |

## Verification
An output-register write and the commit pulse selected by the mode bit can land on the same clock edge. The write can be lost, or the previous staged value can be committed instead. The bench raises the write strobe and the acknowledge pulse on the same falling edge while in acknowledge mode. One cycle later it expects the pads to show the new byte rather than the older staged one. Override and open-drain settings are also changed while committed data stays in place, to show that each only reshapes the pad view and leaves the stored value intact.

// File: rtl/gpio_bank_core.sv
`timescale 1ns/1ps
module gpio_bank_core #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [5:0]                  wr_addr,
  input  logic [BANK_W-1:0]           wr_data,
  input  logic [5:0]                  rd_addr,
  output logic [BANK_W-1:0]           rd_data,
  input  logic                        stop_evt,
  input  logic                        ack_evt,
  input  logic                        oe_pin,
  input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
  output logic [NUM_BANKS*BANK_W-1:0] pad_out,
  output logic [NUM_BANKS*BANK_W-1:0] pad_oe
);
  localparam int PINS = NUM_BANKS * BANK_W;
  localparam logic [2:0] G_IN = 3'd0, G_OUT = 3'd1, G_INV = 3'd2,
                         G_DIR = 3'd3, G_MSK = 3'd4, G_CTL = 3'd5;
  localparam logic [2:0] C_OD = 3'd0, C_ALL = 3'd1, C_MODE = 3'd2;

  logic [PINS-1:0]      shadow_q, shadow_nxt, live_q, dir_q, inv_q, msk_q;
  logic [NUM_BANKS-1:0] od_q, all_en_q;
  logic                 fill_q, ack_mode_q, oe_pol_q;

  wire [2:0] wgrp = wr_addr[5:3];
  wire [2:0] widx = wr_addr[2:0];
  wire [2:0] rgrp = rd_addr[5:3];
  wire [2:0] ridx = rd_addr[2:0];

  wire commit = ack_mode_q ? ack_evt : stop_evt;
  wire oe_act = (oe_pin == oe_pol_q);
  wire [PINS-1:0] in_view = pad_in ^ inv_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    wire bank_wr = wr_en && (widx == 3'(b));
    logic [BANK_W-1:0] eff;

    assign shadow_nxt[LO +: BANK_W] = (bank_wr && wgrp == G_OUT) ? wr_data
                                                                 : shadow_q[LO +: BANK_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[LO +: BANK_W] <= '0;
        live_q[LO +: BANK_W]   <= '0;
        dir_q[LO +: BANK_W]    <= '1;
        inv_q[LO +: BANK_W]    <= '0;
        msk_q[LO +: BANK_W]    <= '1;
      end else begin
        shadow_q[LO +: BANK_W] <= shadow_nxt[LO +: BANK_W];
        if (commit) live_q[LO +: BANK_W] <= shadow_nxt[LO +: BANK_W];
        if (bank_wr) begin
          case (wgrp)
            G_INV:   inv_q[LO +: BANK_W] <= wr_data;
            G_DIR:   dir_q[LO +: BANK_W] <= wr_data;
            G_MSK:   msk_q[LO +: BANK_W] <= wr_data;
            default: ;
          endcase
        end
      end
    end

    assign eff = all_en_q[b] ? {BANK_W{fill_q}} : live_q[LO +: BANK_W];
    assign pad_out[LO +: BANK_W] = od_q[b] ? '0 : eff;
    assign pad_oe[LO +: BANK_W]  = {BANK_W{oe_act}} & ~dir_q[LO +: BANK_W]
                                   & (od_q[b] ? ~eff : {BANK_W{1'b1}});

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      od_q[b] |-> ((pad_oe[LO +: BANK_W] & pad_out[LO +: BANK_W]) == '0)); // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q       <= '0;
      all_en_q   <= '0;
      fill_q     <= 1'b1;
      ack_mode_q <= 1'b0;
      oe_pol_q   <= 1'b0;
    end else if (wr_en && wgrp == G_CTL) begin
      case (widx)
        C_OD:  od_q <= wr_data[NUM_BANKS-1:0];
        C_ALL: begin
          fill_q   <= wr_data[BANK_W-1];
          all_en_q <= wr_data[NUM_BANKS-1:0];
        end
        C_MODE: begin
          ack_mode_q <= wr_data[0];
          oe_pol_q   <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (rgrp == G_CTL) begin
      case (ridx)
        C_OD:   rd_data[NUM_BANKS-1:0] = od_q;
        C_ALL:  begin
          rd_data[BANK_W-1]      = fill_q;
          rd_data[NUM_BANKS-1:0] = all_en_q;
        end
        C_MODE: rd_data[1:0] = {oe_pol_q, ack_mode_q};
        default: ;
      endcase
    end else if (int'(ridx) < NUM_BANKS) begin
      case (rgrp)
        G_IN:    rd_data = in_view[int'(ridx)*BANK_W +: BANK_W];
        G_OUT:   rd_data = shadow_q[int'(ridx)*BANK_W +: BANK_W];
        G_INV:   rd_data = inv_q[int'(ridx)*BANK_W +: BANK_W];
        G_DIR:   rd_data = dir_q[int'(ridx)*BANK_W +: BANK_W];
        G_MSK:   rd_data = msk_q[int'(ridx)*BANK_W +: BANK_W];
        default: ;
      endcase
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_q)); // R3
  AST_STOP_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_mode_q && stop_evt && !wr_en) |=> (live_q == $past(shadow_q))); // R4
  AST_ACK_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mode_q && ack_evt && !wr_en) |=> (live_q == $past(shadow_q))); // R5
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_pin != oe_pol_q) |-> (pad_oe == '0)); // R8
  AST_INPUT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & dir_q) == '0)); // R10
endmodule

// File: tb/gpio_bank_core_bench.sv
`timescale 1ns/1ps
module gpio_bank_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        stop_evt = 1'b0;
  logic        ack_evt = 1'b0;
  logic        oe_pin = 1'b0;
  logic [39:0] pad_in = '0;
  logic [39:0] pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_core u_gpio_bank_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stop_evt(stop_evt), .ack_evt(ack_evt),
    .oe_pin(oe_pin), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(string req, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_evt = 1'b1; @(negedge clk); ack_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "no pad driven", pad_oe, 40'h0);
    for (int b = 0; b < 5; b++) begin
      rd(6'h18 + 6'(b), d); chk("R1", "dir reset", {32'h0, d}, 40'hFF);
      rd(6'h08 + 6'(b), d); chk("R1", "out reset", {32'h0, d}, 40'h00);
      rd(6'h10 + 6'(b), d); chk("R1", "inv reset", {32'h0, d}, 40'h00);
      rd(6'h20 + 6'(b), d); chk("R1", "mask reset", {32'h0, d}, 40'hFF);
    end
    rd(6'h29, d); chk("R1", "override reset", {32'h0, d}, 40'h80);
    rd(6'h28, d); chk("R1", "open-drain reset", {32'h0, d}, 40'h00);
    rd(6'h2A, d); chk("R1", "mode reset", {32'h0, d}, 40'h00);
  endtask

  task automatic t_input();
    logic [7:0] d;
    @(negedge clk); pad_in = 40'h12_C3_96_5A_E1;
    rd(6'h02, d); chk("R2", "raw input bank2", {32'h0, d}, 40'h96);
    wr(6'h12, 8'h0F);
    rd(6'h02, d); chk("R2", "inverted input bank2", {32'h0, d}, 40'h99);
    wr(6'h1A, 8'h00);
    rd(6'h02, d); chk("R2", "input read on output pins", {32'h0, d}, 40'h99);
  endtask

  task automatic t_staged_stop();
    logic [7:0] d;
    wr(6'h18, 8'h00);
    wr(6'h08, 8'hA5);
    chk("R3", "staged value not on pads", {32'h0, pad_out[7:0]}, 40'h00);
    chk("R3", "bank0 driven", {32'h0, pad_oe[7:0]}, 40'hFF);
    rd(6'h08, d); chk("R3", "readback of staged value", {32'h0, d}, 40'hA5);
    pulse_ack();
    chk("R4", "ack ignored in stop mode", {32'h0, pad_out[7:0]}, 40'h00);
    pulse_stop();
    chk("R4", "stop commits", {32'h0, pad_out[7:0]}, 40'hA5);
  endtask

  task automatic t_ack_mode();
    wr(6'h2A, 8'h01);
    wr(6'h08, 8'h3C);
    chk("R5", "staged not on pads", {32'h0, pad_out[7:0]}, 40'hA5);
    pulse_stop();
    chk("R5", "stop ignored in ack mode", {32'h0, pad_out[7:0]}, 40'hA5);
    pulse_ack();
    chk("R5", "ack commits", {32'h0, pad_out[7:0]}, 40'h3C);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); wr_en = 1'b1; wr_addr = 6'h08; wr_data = 8'hF0; ack_evt = 1'b1;
    @(negedge clk); wr_en = 1'b0; ack_evt = 1'b0;
    chk("R6", "same-cycle write committed", {32'h0, pad_out[7:0]}, 40'hF0);
    wr(6'h2A, 8'h00);
  endtask

  task automatic t_override();
    wr(6'h19, 8'h00);
    wr(6'h09, 8'h11);
    pulse_stop();
    chk("R7", "bank1 live value", {32'h0, pad_out[15:8]}, 40'h11);
    wr(6'h29, 8'h82);
    chk("R7", "bank1 forced high", {32'h0, pad_out[15:8]}, 40'hFF);
    chk("R7", "bank0 untouched", {32'h0, pad_out[7:0]}, 40'hF0);
    wr(6'h29, 8'h02);
    chk("R7", "bank1 forced low", {32'h0, pad_out[15:8]}, 40'h00);
    wr(6'h29, 8'h88);
    chk("R7", "override on input bank stays undriven", {32'h0, pad_oe[31:24]}, 40'h00);
    wr(6'h29, 8'h80);
    chk("R7", "bank1 restored", {32'h0, pad_out[15:8]}, 40'h11);
  endtask

  task automatic t_oe_pol();
    @(negedge clk); oe_pin = 1'b1; #1;
    chk("R8", "low-active oe released", pad_oe, 40'h0);
    wr(6'h2A, 8'h02);
    chk("R8", "high-active oe drives", {32'h0, pad_oe[7:0]}, 40'hFF);
    @(negedge clk); oe_pin = 1'b0; #1;
    chk("R8", "high-active oe released", pad_oe, 40'h0);
    wr(6'h2A, 8'h00);
    chk("R8", "default polarity drives", {32'h0, pad_oe[7:0]}, 40'hFF);
  endtask

  task automatic t_open_drain();
    wr(6'h28, 8'h01);
    chk("R9", "od level low", {32'h0, pad_out[7:0]}, 40'h00);
    chk("R9", "od drives zeros only", {32'h0, pad_oe[7:0]}, 40'h0F);
    chk("R9", "bank1 still push-pull", {32'h0, pad_out[15:8]}, 40'h11);
    wr(6'h28, 8'h00);
    chk("R9", "push-pull restored", {32'h0, pad_out[7:0]}, 40'hF0);
  endtask

  task automatic t_direction();
    wr(6'h18, 8'h0F);
    chk("R10", "only output pins driven", {32'h0, pad_oe[7:0]}, 40'hF0);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(6'h02, 8'hFF);
    rd(6'h02, d); chk("R11", "input group not writable", {32'h0, d}, 40'h99);
    wr(6'h0D, 8'hFF);
    pulse_stop();
    chk("R11", "bank5 write changes no pad", pad_out, {8'h00, 8'h00, 8'h00, 8'h11, 8'hF0});
    rd(6'h08, d); chk("R11", "bank0 staged unchanged", {32'h0, d}, 40'hF0);
    wr(6'h23, 8'h5A);
    rd(6'h23, d); chk("R11", "mask readback", {32'h0, d}, 40'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_input();
    t_staged_stop();
    t_ack_mode();
    t_same_cycle();
    t_override();
    t_oe_pol();
    t_open_drain();
    t_direction();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule